// File: doc/BRIEF.md
# Permanent Fault Restart Monitor

This block sits beside a fault-protected processor pipeline and watches the strobes that report an instruction being restarted after a detected fault. A single restart is a normal recovery. An unbroken run of restarts, with no instruction retiring between them, suggests that the fault is not transient. The block counts such runs against a limit set by software. When the count reaches the limit, it escalates.

The block escalates in one of two ways. In direct mode, reaching the limit raises an unrecoverable-error flag on a dedicated output, where an external supervisor can see it. In predictor-first mode, the block first turns off all branch prediction, because a fault in a predictor can keep the pipeline flushing. The count then starts again. The unrecoverable-error flag rises only if restarts keep coming until a second run reaches the limit. Both outputs are sticky until reset.

Top module: `fault_restart_monitor`

## Requirements
- R1: After a synchronous active-low reset, `pred_off_o` and `fatal_o` are both 0.
- R2: With the monitor enabled, direct mode selected and limit L (1..15), `fatal_o` is 1 in the cycle after the clock edge that samples the L-th consecutive restart strobe, and 0 before that edge.
- R3: A retire strobe without a restart strobe in the same cycle clears the consecutive-restart count to zero. A cycle with both strobes counts as a restart.
- R4: While `cfg_en_i` is 0 the count is held at zero and neither output can rise. After enabling, a full run of L restarts is needed to escalate.
- R5: A limit value of 0 disables escalation: no number of restarts raises either output.
- R6: In predictor-first mode (`cfg_pred_first_i` = 1), the L-th consecutive restart raises `pred_off_o` one cycle later and leaves `fatal_o` at 0.
- R7: After prediction is turned off, the count restarts from zero. `fatal_o` rises one cycle after the L-th further consecutive restart, which is the 2L-th restart in an unbroken run.
- R8: Once set, `fatal_o` and `pred_off_o` each stay 1 until reset, whatever the strobes or configuration do.
- R9: In direct mode `pred_off_o` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_i | input | 1 | One-cycle strobe: an instruction was restarted after a fault |
| retire_i | input | 1 | One-cycle strobe: an instruction retired |
| cfg_en_i | input | 1 | Monitor enable |
| cfg_limit_i | input | CNT_W | Consecutive-restart limit; 0 means never escalate |
| cfg_pred_first_i | input | 1 | 1 selects predictor-first escalation, 0 selects direct |
| pred_off_o | output | 1 | Sticky request to disable all branch predictors |
| fatal_o | output | 1 | Sticky unrecoverable-error flag |

## Verification
The bench builds the block with its default 4-bit limit, so all sixteen limit values fit in one sweep. The sweep crosses every limit with both escalation modes and runs each restart sequence past its expected trigger point. The expected output after the k-th restart comes from comparing k with L or 2L. The small width also keeps the retire-interrupted runs, the disabled runs and the simultaneous-strobe runs short enough to repeat for every non-zero limit.

// File: rtl/frm_pkg.sv
// Package: shared types for the restart monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package frm_pkg;

    // Escalation phase of the monitor.
    typedef enum logic [1:0] {
        PH_ARMED   = 2'd0,   // counting, nothing escalated yet
        PH_PREDOFF = 2'd1,   // predictors disabled, counting again
        PH_LOCKED  = 2'd2    // unrecoverable, frozen until reset
    } frm_phase_e;

endpackage

// File: rtl/frm_run_counter.sv
// Module: counts consecutive restart strobes and flags the strobe that
// reaches the limit. On that strobe the count wraps to zero, ready for the
// next phase.
// Assumes: strobes are one cycle wide; limit 0 means never reach.
module frm_run_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,   // monitor enabled and not locked
    input  logic             restart_i,
    input  logic             retire_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             reach_o     // this restart completes a run
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] last_c;

    // Value the count holds just before the strobe that reaches the limit.
    always_comb begin
        last_c  = limit_i - ONE;
        reach_o = active_i && restart_i && (limit_i != '0) && (run_q == last_c);
    end

    // Count restarts; clear on a clean retire, on a reach, or when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!active_i || reach_o) begin
            run_q <= '0;
        end else if (restart_i) begin
            run_q <= run_q + ONE;
        end else if (retire_i) begin
            run_q <= '0;
        end
    end

endmodule

// File: rtl/frm_escalator.sv
// Module: two-step escalation state machine. A reach event either turns
// prediction off (predictor-first mode, first time) or locks the monitor
// in the unrecoverable state.
// Assumes: reach_i is a single-cycle event from the run counter.
module frm_escalator
    import frm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reach_i,
    input  logic pred_first_i,
    output logic locked_o,
    output logic pred_off_o
);
    frm_phase_e phase_q, phase_d;
    logic       pred_off_q;

    // Next phase on a reach event.
    always_comb begin
        phase_d = phase_q;
        if (reach_i) begin
            unique case (phase_q)
                PH_ARMED:   phase_d = pred_first_i ? PH_PREDOFF : PH_LOCKED;
                PH_PREDOFF: phase_d = PH_LOCKED;
                default:    phase_d = PH_LOCKED;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_ARMED;
        else        phase_q <= phase_d;
    end

    // Sticky predictor-disable flag, set on entry to the predictor-off phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                        pred_off_q <= 1'b0;
        else if (phase_d == PH_PREDOFF)    pred_off_q <= 1'b1;
    end

    assign locked_o   = (phase_q == PH_LOCKED);
    assign pred_off_o = pred_off_q;

endmodule

// File: rtl/fault_restart_monitor.sv
// Module: top of the permanent-fault restart monitor. It joins the run
// counter and the escalation machine. The counter runs only while enabled
// and not yet locked.
// Assumes: synchronous active-low reset; configuration is quasi-static.
module fault_restart_monitor #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             retire_i,
    input  logic             cfg_en_i,
    input  logic [CNT_W-1:0] cfg_limit_i,
    input  logic             cfg_pred_first_i,
    output logic             pred_off_o,
    output logic             fatal_o
);
    logic reach_w;
    logic locked_w;
    logic active_w;

    // Counting stops once locked so the state is frozen.
    assign active_w = cfg_en_i && !locked_w;

    frm_run_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active_w),
        .restart_i (restart_i),
        .retire_i  (retire_i),
        .limit_i   (cfg_limit_i),
        .reach_o   (reach_w)
    );

    frm_escalator u_esc (
        .clk          (clk),
        .rst_n        (rst_n),
        .reach_i      (reach_w),
        .pred_first_i (cfg_pred_first_i),
        .locked_o     (locked_w),
        .pred_off_o   (pred_off_o)
    );

    assign fatal_o = locked_w;

endmodule

// File: rtl/fault_restart_monitor_chk.sv
// Module: property checker for the restart monitor, bound to the top.
// Assumes: observes top-level ports only.
module fault_restart_monitor_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart_i,
    input logic             cfg_en_i,
    input logic [CNT_W-1:0] cfg_limit_i,
    input logic             cfg_pred_first_i,
    input logic             pred_off_o,
    input logic             fatal_o
);
    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> fatal_o); // R8
    AST_PREDOFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pred_off_o |=> pred_off_o); // R8
    AST_FATAL_NEEDS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_o) |-> $past(restart_i && cfg_en_i)); // R4
    AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_o) |-> ($past(cfg_limit_i) != '0)); // R5
    AST_PREDOFF_BEFORE_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fatal_o) && $past(cfg_pred_first_i)) |-> $past(pred_off_o)); // R7
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pred_off_o) |-> !$rose(fatal_o)); // R6
    AST_DIRECT_NO_PREDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pred_off_o) |-> $past(cfg_pred_first_i)); // R9
endmodule

bind fault_restart_monitor fault_restart_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .restart_i        (restart_i),
    .cfg_en_i         (cfg_en_i),
    .cfg_limit_i      (cfg_limit_i),
    .cfg_pred_first_i (cfg_pred_first_i),
    .pred_off_o       (pred_off_o),
    .fatal_o          (fatal_o)
);

// File: tb/fault_restart_monitor_tb.sv
module fault_restart_monitor_tb;
    localparam int CNT_W = 4;
    localparam int LMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart_i = 1'b0;
    logic retire_i = 1'b0;
    logic cfg_en_i = 1'b0;
    logic [CNT_W-1:0] cfg_limit_i = '0;
    logic cfg_pred_first_i = 1'b0;
    logic pred_off_o;
    logic fatal_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    fault_restart_monitor #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .retire_i(retire_i),
        .cfg_en_i(cfg_en_i), .cfg_limit_i(cfg_limit_i),
        .cfg_pred_first_i(cfg_pred_first_i),
        .pred_off_o(pred_off_o), .fatal_o(fatal_o)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, got, exp, $time);
        end
    endtask

    // One cycle of strobes; returns at the next falling edge, when the
    // registered outputs already show the effect of these strobes.
    task automatic step(input logic r, input logic t);
        restart_i = r;
        retire_i  = t;
        @(negedge clk);
        restart_i = 1'b0;
        retire_i  = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 pred_off after reset", pred_off_o, 1'b0);
        chk("R1 fatal after reset", fatal_o, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // Sweep: every limit, both modes, unbroken restart runs.
        for (int mode = 0; mode < 2; mode++) begin
            for (int lim = 0; lim <= LMAX; lim++) begin
                do_reset();
                cfg_en_i = 1'b1;
                cfg_limit_i = CNT_W'(lim);
                cfg_pred_first_i = (mode == 1);
                for (int k = 1; k <= 2 * lim + 3; k++) begin
                    logic ep, ef;
                    step(1'b1, 1'b0);
                    if (lim == 0) begin
                        ep = 1'b0; ef = 1'b0;
                    end else if (mode == 1) begin
                        ep = (k >= lim); ef = (k >= 2 * lim);
                    end else begin
                        ep = 1'b0; ef = (k >= lim);
                    end
                    if (lim == 0) begin
                        chk("R5 pred_off with zero limit", pred_off_o, ep);
                        chk("R5 fatal with zero limit", fatal_o, ef);
                    end else if (mode == 1) begin
                        chk("R6 pred_off in predictor-first run", pred_off_o, ep);
                        chk("R7 fatal after second run", fatal_o, ef);
                    end else begin
                        chk("R9 pred_off in direct run", pred_off_o, ep);
                        chk("R2 fatal in direct run", fatal_o, ef);
                    end
                end
                // Sticky against retires and a dropped enable.
                cfg_en_i = 1'b0;
                step(1'b0, 1'b1);
                step(1'b0, 1'b1);
                if (lim != 0) begin
                    chk("R8 fatal stays set", fatal_o, 1'b1);
                    chk("R8 pred_off stays set", pred_off_o, (mode == 1));
                end
            end
        end

        // Retire breaks a run; a restart with a retire still counts.
        for (int lim = 2; lim <= LMAX; lim++) begin
            do_reset();
            cfg_en_i = 1'b1; cfg_limit_i = CNT_W'(lim); cfg_pred_first_i = 1'b0;
            for (int k = 0; k < lim - 1; k++) step(1'b1, 1'b0);
            step(1'b0, 1'b1);
            for (int k = 0; k < lim - 1; k++) step(1'b1, 1'b0);
            chk("R3 run cleared by retire", fatal_o, 1'b0);
            step(1'b1, 1'b1);
            chk("R3 restart with retire counts", fatal_o, 1'b1);
        end

        // Retire during predictor-off phase restarts the second run.
        for (int lim = 1; lim <= LMAX; lim++) begin
            do_reset();
            cfg_en_i = 1'b1; cfg_limit_i = CNT_W'(lim); cfg_pred_first_i = 1'b1;
            for (int k = 0; k < lim; k++) step(1'b1, 1'b0);
            chk("R6 pred_off after first run", pred_off_o, 1'b1);
            for (int k = 0; k < lim - 1; k++) step(1'b1, 1'b0);
            step(1'b0, 1'b1);
            for (int k = 0; k < lim - 1; k++) step(1'b1, 1'b0);
            chk("R7 second run cleared by retire", fatal_o, 1'b0);
            step(1'b1, 1'b0);
            chk("R7 fatal after full second run", fatal_o, 1'b1);
        end

        // Disabled monitor ignores restarts and counts from zero on enable.
        for (int lim = 1; lim <= LMAX; lim++) begin
            do_reset();
            cfg_en_i = 1'b0; cfg_limit_i = CNT_W'(lim); cfg_pred_first_i = 1'b0;
            for (int k = 0; k < 20; k++) step(1'b1, 1'b0);
            chk("R4 no fatal while disabled", fatal_o, 1'b0);
            chk("R4 no pred_off while disabled", pred_off_o, 1'b0);
            cfg_en_i = 1'b1;
            for (int k = 0; k < lim - 1; k++) step(1'b1, 1'b0);
            chk("R4 count starts at zero on enable", fatal_o, 1'b0);
            step(1'b1, 1'b0);
            chk("R4 fatal after full run once enabled", fatal_o, 1'b1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule